// File: doc/BRIEF.md
# Centralized Scoreboard Hazard Controller

This block is the central issue controller for a core with several non-pipelined execution units. Every instruction passes through four phases: it is issued to a unit, it reads its operands, it executes, and it writes its result. The controller keeps one status entry per execution unit and a destination table that records which unit will produce each register. Each cycle it decides which instruction may advance. Structural and write-after-write hazards stall an instruction at issue. Read-after-write hazards hold it at operand read. Write-after-read hazards hold back its result write.

The decode stage presents one decoded instruction per cycle: an operation code, a destination, two sources and the class of unit it needs. The units report the end of execution with a one-cycle done pulse. The controller answers with an issue acceptance and the chosen unit, a per-unit operand read enable, and a per-unit result write grant. Instructions are named by the index of the unit that holds them. No tags are used. The core has no commit stage, so interrupts are imprecise. Datapath values and execution latency are handled outside the block.

Top module: `scoreboard_ctrl`

## Requirements
- R1: An instruction with `in_valid` high is accepted in the same cycle (`issue_ok` = 1) only when an idle unit of the requested class exists. `issue_unit` is then the lowest-indexed idle unit of that class. With the default map, class 0 = unit 0, class 1 = units 1 and 2, class 2 = unit 3, class 3 = unit 4. If no such unit is idle, `issue_ok` is 0.
- R2: An instruction whose destination is still owed by an active unit is not accepted. This holds even in the cycle in which that owner receives its write grant.
- R3: `read_en[i]` is high for exactly one cycle per instruction held in unit i. It is high only once neither source has a pending producer. During that cycle `unit_op[i*OP_W +: OP_W]` carries the operation code issued to unit i.
- R4: A source produced by another active unit withholds the consumer's `read_en`. The withholding lasts until the producer's write grant. `read_en` rises in the cycle after that grant.
- R5: A done pulse is honoured only while the unit is executing, that is, after its read cycle. A pulse that arrives in the issue cycle, in the read cycle or while the unit is idle has no effect. Such a unit gets no write grant until a later pulse arrives.
- R6: A unit that has finished is denied its write grant while another unit still holds that destination register as an unread source that is already marked ready. The grant follows once that reader has had its read cycle.
- R7: At most one write grant is raised per cycle. Among finished units that are free of write-after-read hazards, the lowest index wins. The others keep waiting.
- R8: A write grant frees the unit on the next clock edge. It also clears the unit's ownership of its destination. From the next cycle the unit and that destination can be used by a new instruction.
- R9: An instruction can be accepted in the same cycle in which one of its sources receives its write grant. That source then counts as available, and its `read_en` appears in the following cycle.
- R10: After reset all units are idle and the destination table is empty. `read_en`, `write_grant` and `issue_ok` are 0 while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | OP_W | Operation code |
| in_class | input | CLS_W | Class of execution unit required |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| unit_done | input | NUM_FU | Per-unit end-of-execution pulse |
| issue_ok | output | 1 | Instruction accepted this cycle |
| issue_unit | output | FU_W | Unit receiving the accepted instruction |
| read_en | output | NUM_FU | Per-unit operand read enable |
| write_grant | output | NUM_FU | Per-unit result write grant |
| unit_op | output | NUM_FU*OP_W | Operation code held by each unit |

## Verification
Two events can land on the same clock edge: an instruction is accepted, and a result write is granted to the producer of one of that instruction's sources, or to the owner of its destination. The bench provokes both cases. It watches a reference model's pending grant and presents, in exactly that cycle, a consumer of the granted register (R9), and in a separate case a second writer of it (R2). It then judges acceptance in that cycle and the read enable in the following one. Random traffic over a narrow range of registers, with done pulses that are sometimes stray, makes these coincidences and the write-after-read holds frequent. Every cycle is compared against the model.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Phase of the instruction held by one execution unit
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,   // waiting for operands
      ST_EXEC = 2'd2,   // operands read, executing
      ST_DONE = 2'd3    // finished, waiting for a write grant
   } unit_state_e;

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
   parameter int NUM_REG = 32,
   parameter int REG_W   = 5,
   parameter int FU_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic [REG_W-1:0] set_reg,
   input  logic [FU_W-1:0]  set_fu,
   input  logic             clr_we,
   input  logic [REG_W-1:0] clr_reg,
   input  logic [FU_W-1:0]  clr_fu,
   input  logic [REG_W-1:0] a_reg,
   output logic             a_pend,
   output logic [FU_W-1:0]  a_fu,
   input  logic [REG_W-1:0] b_reg,
   output logic             b_pend,
   output logic [FU_W-1:0]  b_fu,
   input  logic [REG_W-1:0] c_reg,
   output logic             c_pend
);

   logic [NUM_REG-1:0] pend_q;
   logic [FU_W-1:0]    owner_q [NUM_REG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         for (int r = 0; r < NUM_REG; r++) owner_q[r] <= '0;
      end else begin
         // release only when the writer still owns the register
         if (clr_we && pend_q[clr_reg] && (owner_q[clr_reg] == clr_fu))
            pend_q[clr_reg] <= 1'b0;
         if (set_we) begin
            pend_q[set_reg]  <= 1'b1;
            owner_q[set_reg] <= set_fu;
         end
      end
   end

   assign a_pend = pend_q[a_reg];
   assign a_fu   = owner_q[a_reg];
   assign b_pend = pend_q[b_reg];
   assign b_fu   = owner_q[b_reg];
   assign c_pend = pend_q[c_reg];

endmodule

// File: rtl/sb_unit_entry.sv
module sb_unit_entry
   import sb_pkg::*;
#(
   parameter int OP_W  = 4,
   parameter int REG_W = 5,
   parameter int FU_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OP_W-1:0]  ld_op,
   input  logic [REG_W-1:0] ld_dst,
   input  logic [REG_W-1:0] ld_src1,
   input  logic [REG_W-1:0] ld_src2,
   input  logic             ld_q1_v,
   input  logic [FU_W-1:0]  ld_q1,
   input  logic             ld_q2_v,
   input  logic [FU_W-1:0]  ld_q2,
   input  logic             wake_v,
   input  logic [FU_W-1:0]  wake_fu,
   input  logic             exec_done,
   input  logic             free_i,
   output unit_state_e      state_o,
   output logic [OP_W-1:0]  op_o,
   output logic [REG_W-1:0] dst_o,
   output logic [REG_W-1:0] src1_o,
   output logic [REG_W-1:0] src2_o,
   output logic             rdy1_o,
   output logic             rdy2_o,
   output logic             read_req_o
);

   unit_state_e      st_q;
   logic [OP_W-1:0]  op_q;
   logic [REG_W-1:0] dst_q, s1_q, s2_q;
   logic [FU_W-1:0]  q1_q, q2_q;
   logic             q1_v_q, q2_v_q, r1_q, r2_q;

   assign read_req_o = (st_q == ST_WAIT) && r1_q && r2_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= '0;
         dst_q  <= '0;
         s1_q   <= '0;
         s2_q   <= '0;
         q1_q   <= '0;
         q2_q   <= '0;
         q1_v_q <= 1'b0;
         q2_v_q <= 1'b0;
         r1_q   <= 1'b0;
         r2_q   <= 1'b0;
      end else if (free_i) begin
         st_q   <= ST_IDLE;
         r1_q   <= 1'b0;
         r2_q   <= 1'b0;
         q1_v_q <= 1'b0;
         q2_v_q <= 1'b0;
      end else if (load) begin
         st_q   <= ST_WAIT;
         op_q   <= ld_op;
         dst_q  <= ld_dst;
         s1_q   <= ld_src1;
         s2_q   <= ld_src2;
         q1_q   <= ld_q1;
         q2_q   <= ld_q2;
         q1_v_q <= ld_q1_v;
         q2_v_q <= ld_q2_v;
         r1_q   <= !ld_q1_v;
         r2_q   <= !ld_q2_v;
      end else begin
         unique case (st_q)
            ST_WAIT: begin
               if (read_req_o) begin
                  // operands taken: clear flags so WAR checks see the read
                  st_q <= ST_EXEC;
                  r1_q <= 1'b0;
                  r2_q <= 1'b0;
               end else begin
                  if (wake_v && q1_v_q && (q1_q == wake_fu)) begin
                     r1_q   <= 1'b1;
                     q1_v_q <= 1'b0;
                  end
                  if (wake_v && q2_v_q && (q2_q == wake_fu)) begin
                     r2_q   <= 1'b1;
                     q2_v_q <= 1'b0;
                  end
               end
            end
            ST_EXEC: if (exec_done) st_q <= ST_DONE;
            default: ;
         endcase
      end
   end

   assign state_o = st_q;
   assign op_o    = op_q;
   assign dst_o   = dst_q;
   assign src1_o  = s1_q;
   assign src2_o  = s2_q;
   assign rdy1_o  = r1_q;
   assign rdy2_o  = r2_q;

endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel #(
   parameter int                        NUM_FU    = 5,
   parameter int                        FU_W      = 3,
   parameter int                        CLS_W     = 2,
   parameter logic [NUM_FU*CLS_W-1:0]   CLASS_MAP = '0
) (
   input  logic [CLS_W-1:0]  req_class,
   input  logic [NUM_FU-1:0] unit_free,
   output logic              hit,
   output logic [FU_W-1:0]   sel
);

   logic [NUM_FU-1:0] cls_ok;

   for (genvar g = 0; g < NUM_FU; g++) begin : g_match
      assign cls_ok[g] = unit_free[g] &&
                         (CLASS_MAP[g*CLS_W +: CLS_W] == req_class);
   end

   // lowest matching index wins
   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int i = NUM_FU - 1; i >= 0; i--) begin
         if (cls_ok[i]) begin
            hit = 1'b1;
            sel = FU_W'(i);
         end
      end
   end

endmodule

// File: rtl/sb_write_arb.sv
module sb_write_arb #(
   parameter int NUM_FU = 5,
   parameter int REG_W  = 5,
   parameter int FU_W   = 3
) (
   input  logic [NUM_FU-1:0]       fin,
   input  logic [NUM_FU-1:0]       rdy1,
   input  logic [NUM_FU-1:0]       rdy2,
   input  logic [NUM_FU*REG_W-1:0] dst_flat,
   input  logic [NUM_FU*REG_W-1:0] src1_flat,
   input  logic [NUM_FU*REG_W-1:0] src2_flat,
   output logic [NUM_FU-1:0]       grant,
   output logic                    grant_v,
   output logic [FU_W-1:0]         grant_fu,
   output logic [REG_W-1:0]        grant_dst
);

   logic [NUM_FU*NUM_FU-1:0] war_mat;
   logic [NUM_FU-1:0]        cand;

   for (genvar gi = 0; gi < NUM_FU; gi++) begin : g_wr
      for (genvar gk = 0; gk < NUM_FU; gk++) begin : g_rd
         if (gk == gi) begin : g_self
            assign war_mat[gi*NUM_FU+gk] = 1'b0;
         end else begin : g_other
            assign war_mat[gi*NUM_FU+gk] =
               (rdy1[gk] && (src1_flat[gk*REG_W +: REG_W] == dst_flat[gi*REG_W +: REG_W])) ||
               (rdy2[gk] && (src2_flat[gk*REG_W +: REG_W] == dst_flat[gi*REG_W +: REG_W]));
         end
      end
      assign cand[gi]  = fin[gi] && !(|war_mat[gi*NUM_FU +: NUM_FU]);
      assign grant[gi] = grant_v && (grant_fu == FU_W'(gi));
   end

   always_comb begin
      grant_v   = 1'b0;
      grant_fu  = '0;
      grant_dst = '0;
      for (int i = NUM_FU - 1; i >= 0; i--) begin
         if (cand[i]) begin
            grant_v   = 1'b1;
            grant_fu  = FU_W'(i);
            grant_dst = dst_flat[i*REG_W +: REG_W];
         end
      end
   end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
   import sb_pkg::*;
#(
   parameter int                      NUM_FU    = 5,
   parameter int                      NUM_REG   = 32,
   parameter int                      OP_W      = 4,
   parameter int                      CLS_W     = 2,
   // class per unit, unit 0 in the low bits: int, mul, mul, add, div
   parameter logic [NUM_FU*CLS_W-1:0] CLASS_MAP = 10'b11_10_01_01_00,
   localparam int                     REG_W     = $clog2(NUM_REG),
   localparam int                     FU_W      = $clog2(NUM_FU)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [OP_W-1:0]        in_op,
   input  logic [CLS_W-1:0]       in_class,
   input  logic [REG_W-1:0]       in_dst,
   input  logic [REG_W-1:0]       in_src1,
   input  logic [REG_W-1:0]       in_src2,
   input  logic [NUM_FU-1:0]      unit_done,
   output logic                   issue_ok,
   output logic [FU_W-1:0]        issue_unit,
   output logic [NUM_FU-1:0]      read_en,
   output logic [NUM_FU-1:0]      write_grant,
   output logic [NUM_FU*OP_W-1:0] unit_op
);

   if (NUM_FU < 2) begin : g_bad_fu
      $error("scoreboard_ctrl: NUM_FU must be at least 2");
   end
   if (NUM_REG < 2 || NUM_REG != (1 << REG_W)) begin : g_bad_reg
      $error("scoreboard_ctrl: NUM_REG must be a power of two, at least 2");
   end
   if (OP_W < 1 || CLS_W < 1) begin : g_bad_w
      $error("scoreboard_ctrl: OP_W and CLS_W must be positive");
   end

   unit_state_e              ent_st [NUM_FU];
   logic [NUM_FU*REG_W-1:0]  dst_flat, src1_flat, src2_flat;
   logic [NUM_FU-1:0]        rdy1, rdy2, fin, unit_idle;

   logic             s1_pend, s2_pend, d_pend;
   logic [FU_W-1:0]  s1_fu, s2_fu;
   logic             sel_hit;
   logic [FU_W-1:0]  sel_fu;
   logic             wr_v;
   logic [FU_W-1:0]  wr_fu;
   logic [REG_W-1:0] wr_dst;
   logic             q1_v, q2_v;

   sb_reg_status #(.NUM_REG(NUM_REG), .REG_W(REG_W), .FU_W(FU_W)) u_regstat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_we  (issue_ok),
      .set_reg (in_dst),
      .set_fu  (sel_fu),
      .clr_we  (wr_v),
      .clr_reg (wr_dst),
      .clr_fu  (wr_fu),
      .a_reg   (in_src1),
      .a_pend  (s1_pend),
      .a_fu    (s1_fu),
      .b_reg   (in_src2),
      .b_pend  (s2_pend),
      .b_fu    (s2_fu),
      .c_reg   (in_dst),
      .c_pend  (d_pend)
   );

   sb_issue_sel #(.NUM_FU(NUM_FU), .FU_W(FU_W), .CLS_W(CLS_W),
                  .CLASS_MAP(CLASS_MAP)) u_sel (
      .req_class (in_class),
      .unit_free (unit_idle),
      .hit       (sel_hit),
      .sel       (sel_fu)
   );

   // structural and WAW checks gate issue
   assign issue_ok   = in_valid && sel_hit && !d_pend;
   assign issue_unit = sel_fu;

   // a producer granted this cycle counts as already delivered
   assign q1_v = s1_pend && !(wr_v && (s1_fu == wr_fu));
   assign q2_v = s2_pend && !(wr_v && (s2_fu == wr_fu));

   for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
      sb_unit_entry #(.OP_W(OP_W), .REG_W(REG_W), .FU_W(FU_W)) u_ent (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (issue_ok && (sel_fu == FU_W'(g))),
         .ld_op      (in_op),
         .ld_dst     (in_dst),
         .ld_src1    (in_src1),
         .ld_src2    (in_src2),
         .ld_q1_v    (q1_v),
         .ld_q1      (s1_fu),
         .ld_q2_v    (q2_v),
         .ld_q2      (s2_fu),
         .wake_v     (wr_v),
         .wake_fu    (wr_fu),
         .exec_done  (unit_done[g]),
         .free_i     (write_grant[g]),
         .state_o    (ent_st[g]),
         .op_o       (unit_op[g*OP_W +: OP_W]),
         .dst_o      (dst_flat[g*REG_W +: REG_W]),
         .src1_o     (src1_flat[g*REG_W +: REG_W]),
         .src2_o     (src2_flat[g*REG_W +: REG_W]),
         .rdy1_o     (rdy1[g]),
         .rdy2_o     (rdy2[g]),
         .read_req_o (read_en[g])
      );
      assign unit_idle[g] = (ent_st[g] == ST_IDLE);
      assign fin[g]       = (ent_st[g] == ST_DONE);
   end

   sb_write_arb #(.NUM_FU(NUM_FU), .REG_W(REG_W), .FU_W(FU_W)) u_arb (
      .fin       (fin),
      .rdy1      (rdy1),
      .rdy2      (rdy2),
      .dst_flat  (dst_flat),
      .src1_flat (src1_flat),
      .src2_flat (src2_flat),
      .grant     (write_grant),
      .grant_v   (wr_v),
      .grant_fu  (wr_fu),
      .grant_dst (wr_dst)
   );

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
   parameter int NUM_FU = 5,
   parameter int FU_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_ok,
   input logic [FU_W-1:0]   issue_unit,
   input logic [NUM_FU-1:0] read_en,
   input logic [NUM_FU-1:0] write_grant,
   input logic [NUM_FU-1:0] unit_idle
);

   assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(write_grant))
      else $error("R7: more than one write grant");

   assert_issue_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ok |-> unit_idle[issue_unit])
      else $error("R1: issue to a busy unit");

   assert_read_write_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (read_en & write_grant) == '0)
      else $error("R3: read and write in one cycle for a unit");

   for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
      assert_read_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
         read_en[g] |=> !read_en[g])
         else $error("R3: read enable held for two cycles");

      assert_freed_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
         write_grant[g] |=> (unit_idle[g] && !write_grant[g]))
         else $error("R8: unit not freed after write");

      assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
         unit_idle[g] |=> !write_grant[g])
         else $error("R5: write grant without execution");
   end

endmodule

bind scoreboard_ctrl sb_checker #(.NUM_FU(NUM_FU), .FU_W(FU_W)) u_sb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_ok    (issue_ok),
   .issue_unit  (issue_unit),
   .read_en     (read_en),
   .write_grant (write_grant),
   .unit_idle   (unit_idle)
);

// File: tb/sim_scoreboard_ctrl.sv
module sim_scoreboard_ctrl;

   localparam int NF = 5;
   localparam int NR = 32;
   localparam int OW = 4;
   localparam int RW = 5;
   localparam int FW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [OW-1:0]   in_op = '0;
   logic [1:0]      in_class = '0;
   logic [RW-1:0]   in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic [NF-1:0]   unit_done = '0;
   logic            issue_ok;
   logic [FW-1:0]   issue_unit;
   logic [NF-1:0]   read_en, write_grant;
   logic [NF*OW-1:0] unit_op;

   int n_chk = 0;
   int n_bad = 0;

   // model state: 0 idle, 1 waiting, 2 executing, 3 finished
   int m_st [NF];
   int m_dst [NF], m_s1 [NF], m_s2 [NF], m_q1 [NF], m_q2 [NF], m_op [NF];
   bit m_r1 [NF], m_r2 [NF];
   int m_reg [NR];

   always #10 clk = ~clk;

   scoreboard_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_class(in_class), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .unit_done(unit_done), .issue_ok(issue_ok), .issue_unit(issue_unit),
      .read_en(read_en), .write_grant(write_grant), .unit_op(unit_op)
   );

   function automatic int cls_of(int u);
      if (u == 0) return 0;
      if (u <= 2) return 1;
      if (u == 3) return 2;
      return 3;
   endfunction

   function automatic int exp_issue();
      if (!in_valid) return -1;
      if (m_reg[in_dst] != -1) return -1;
      for (int i = 0; i < NF; i++)
         if (m_st[i] == 0 && cls_of(i) == int'(in_class)) return i;
      return -1;
   endfunction

   function automatic int exp_write();
      for (int i = 0; i < NF; i++) begin
         bit blocked = 0;
         if (m_st[i] != 3) continue;
         for (int k = 0; k < NF; k++)
            if (k != i && m_st[k] == 1 &&
                ((m_s1[k] == m_dst[i] && m_r1[k]) || (m_s2[k] == m_dst[i] && m_r2[k])))
               blocked = 1;
         if (!blocked) return i;
      end
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NF; i++) begin
         m_st[i] = 0; m_q1[i] = -1; m_q2[i] = -1; m_r1[i] = 0; m_r2[i] = 0;
         m_dst[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_op[i] = 0;
      end
      for (int r = 0; r < NR; r++) m_reg[r] = -1;
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // called just after a falling edge with inputs set
   task automatic step(string tag);
      int ei, ew;
      logic [NF-1:0] erd, ewr;
      #1;
      ei = exp_issue();
      ew = exp_write();
      erd = '0; ewr = '0;
      for (int i = 0; i < NF; i++)
         erd[i] = (m_st[i] == 1) && m_r1[i] && m_r2[i];
      if (ew >= 0) ewr[ew] = 1'b1;
      chk(tag, "issue_ok", int'(issue_ok), int'(ei >= 0));
      if (ei >= 0) chk(tag, "issue_unit", int'(issue_unit), ei);
      chk(tag, "read_en", int'(read_en), int'(erd));
      chk(tag, "write_grant", int'(write_grant), int'(ewr));
      for (int i = 0; i < NF; i++)
         if (erd[i]) chk(tag, "unit_op", int'(unit_op[i*OW +: OW]), m_op[i]);
      @(posedge clk);
      for (int i = 0; i < NF; i++)
         if (m_st[i] == 2 && unit_done[i]) m_st[i] = 3;
      for (int i = 0; i < NF; i++)
         if (erd[i]) begin m_st[i] = 2; m_r1[i] = 0; m_r2[i] = 0; end
      if (ew >= 0) begin
         for (int k = 0; k < NF; k++)
            if (m_st[k] == 1) begin
               if (m_q1[k] == ew) begin m_r1[k] = 1; m_q1[k] = -1; end
               if (m_q2[k] == ew) begin m_r2[k] = 1; m_q2[k] = -1; end
            end
         if (m_reg[m_dst[ew]] == ew) m_reg[m_dst[ew]] = -1;
         m_st[ew] = 0;
      end
      if (ei >= 0) begin
         m_st[ei] = 1;
         m_dst[ei] = int'(in_dst); m_s1[ei] = int'(in_src1); m_s2[ei] = int'(in_src2);
         m_op[ei] = int'(in_op);
         m_q1[ei] = m_reg[in_src1]; m_q2[ei] = m_reg[in_src2];
         m_r1[ei] = (m_q1[ei] == -1); m_r2[ei] = (m_q2[ei] == -1);
         m_reg[in_dst] = ei;
      end
      @(negedge clk);
   endtask

   task automatic put(bit v, int cls, int d, int s1, int s2);
      in_valid = v;
      in_class = 2'(cls);
      in_dst   = RW'(d);
      in_src1  = RW'(s1);
      in_src2  = RW'(s2);
      in_op    = OW'($urandom);
   endtask

   task automatic idle_n(string tag, int n);
      in_valid = 1'b0;
      unit_done = '0;
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic drain(string tag);
      in_valid = 1'b0;
      for (int c = 0; c < 200; c++) begin
         bit any = 0;
         for (int i = 0; i < NF; i++) begin
            unit_done[i] = (m_st[i] == 2);
            if (m_st[i] != 0) any = 1;
         end
         if (!any) break;
         step(tag);
      end
      unit_done = '0;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: empty after reset
      idle_n("R10", 2);

      // R1: lowest free unit of a class, stall when class exhausted
      put(1, 1, 1, 3, 4); step("R1");
      put(1, 1, 2, 3, 4); step("R1");
      put(1, 1, 3, 3, 4); step("R1");
      step("R1");
      drain("R8");
      // R8: freed destination reusable
      put(1, 1, 1, 0, 0); step("R8");
      drain("R8");

      // R2: WAW stall
      put(1, 0, 4, 1, 2); step("R2");
      put(1, 2, 4, 1, 2); step("R2");
      step("R2");
      drain("R2");

      // R4: RAW wait until producer writes
      put(1, 1, 6, 1, 2); step("R4");
      put(1, 2, 11, 6, 6); step("R4");
      idle_n("R4", 3);
      unit_done = 5'b00010; step("R4");
      idle_n("R4", 3);
      drain("R4");

      // R6: WAR hold on result write
      put(1, 1, 7, 1, 2); step("R6");
      put(1, 3, 9, 7, 8); step("R6");
      put(1, 2, 8, 1, 2); step("R6");
      idle_n("R6", 1);
      unit_done = 5'b01000; step("R6");
      idle_n("R6", 3);
      unit_done = 5'b00010; step("R6");
      idle_n("R6", 3);
      drain("R6");

      // R9: issue in the cycle the source producer is granted
      put(1, 1, 10, 1, 2); step("R9");
      idle_n("R9", 2);
      unit_done = 5'b00010; step("R9");
      unit_done = '0;
      chk("R9", "grant pending", exp_write(), 1);
      put(1, 2, 12, 10, 3); step("R9");
      idle_n("R9", 2);
      drain("R9");

      // R2: WAW stall also in the cycle the owner is granted
      put(1, 1, 20, 1, 2); step("R2");
      idle_n("R2", 2);
      unit_done = 5'b00010; step("R2");
      unit_done = '0;
      chk("R2", "grant pending", exp_write(), 1);
      put(1, 0, 20, 3, 4); step("R2");
      put(1, 0, 20, 3, 4); step("R2");
      drain("R2");

      // R5: stray done pulses ignored
      put(1, 0, 13, 1, 2); unit_done = 5'b10001; step("R5");
      in_valid = 1'b0; step("R5");
      idle_n("R5", 3);
      unit_done = 5'b00001; step("R5");
      idle_n("R5", 2);
      drain("R5");

      // R7: simultaneous finish, lowest index first
      put(1, 0, 14, 1, 2); step("R7");
      put(1, 2, 15, 1, 2); step("R7");
      idle_n("R7", 2);
      unit_done = 5'b01001; step("R7");
      idle_n("R7", 3);
      drain("R7");

      // random traffic on a narrow register range
      for (int c = 0; c < 4000; c++) begin
         put(($urandom % 10) < 7, int'($urandom % 4), int'($urandom % 8),
             int'($urandom % 8), int'($urandom % 8));
         for (int i = 0; i < NF; i++)
            unit_done[i] = (m_st[i] == 2) ? (($urandom % 10) < 4) : (($urandom % 20) == 0);
         step("R3");
      end
      drain("R3");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule